// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing for a display pipeline. Software programs it through a 32-bit register port. The programmed values are the line and frame lengths, the active area, the sync pulse positions and widths, and the position of a one-cycle "kick" pulse that tells the fetch logic to start the next frame. While the block runs, it shows the current pixel and line coordinates, a data-enable flag, the two sync signals and the kick pulse. Software can read a timestamp that holds a frame counter and the current line.

Every timing register has two copies: a programmed copy and a working copy. When deferred update is off, a write changes both copies at once. When deferred update is on, a write changes only the programmed copy. Software then writes an arm token. The working copy takes the programmed values at the next frame boundary, so a mode change never splits a frame.

A run bit starts and stops the raster. Stopping it clears both counters and forces every timing output low. The frame counter keeps its value.

Top module: `vtg_raster`

## Requirements
- R1: After reset the raster is stopped. All outputs are zero, and every register reads zero.
- R2: The pixel counter runs from 0 up to the horizontal-total field, which holds the line length minus one, and then returns to 0. On that wrap the line counter advances. The line counter returns to 0 after it reaches the vertical-total field.
- R3: `de` is high exactly when the pixel count is below the active-width field and the line count is below the active-height field. Neither active field carries an offset.
- R4: Each sync word has three fields. Bits 13:0 hold the pulse width minus one. Bits 29:16 hold the sync-plus-back-porch length minus one. Bit 31 enables the pulse. With T the total and S the sync-plus-back-porch length, the pulse is high from count T−S for the programmed width. `hsync` follows the pixel count and `vsync` follows the line count. Both are active high.
- R5: The kick word holds a column in bits 13:0, a row in bits 29:16 and an enable in bit 31. With the enable set, `kick` is high for the single cycle in which the pixel and line counts equal that column and row.
- R6: The timestamp word (index 8) returns the frame counter in bits 31:14 and the current line count in bits 13:0. The frame counter increments at each frame wrap.
- R7: The control word (index 0) bit 0 selects deferred update. With it clear, timing writes take effect on the next clock. With it set, timing writes wait for an arm token (index 7, bit 0 = 1). They are then applied at the first frame wrap after the token.
- R8: Bit 0 of the run word (index 6) starts the raster when set and stops it when cleared. One cycle after a stop, both counters are zero and all timing outputs are low. The frame counter is kept.
- R9: Register access uses word indices. Index 1 is horizontal size, 2 is horizontal sync, 3 is vertical size, 4 is vertical sync and 5 is kick. Each of these reads back its programmed copy, with undefined bits zero. A write to the timestamp is ignored. The arm token and all unmapped indices read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (6) | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| pix_x | output | CW (14) | Current pixel count |
| line_y | output | CW (14) | Current line count |
| de | output | 1 | Active-area flag |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| kick | output | 1 | One-cycle frame-fetch start pulse |

## Verification
A bad counter or a bad working copy shows up within one line on `pix_x`, `de` and `hsync`. It shows up within one frame on `line_y`, `vsync` and `kick`, because every output is compared every cycle against a cycle-accurate model in the bench. A deferred update applied too early or too late changes the active width at the wrong frame boundary, so it is visible as a `de` mismatch in the first line after the wrong boundary. A lost or extra frame increment is visible at the next timestamp read.

// File: rtl/vtg_raster.sv
module vtg_raster #(
  parameter int CW = 14,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] line_y,
  output logic          de,
  output logic          hsync,
  output logic          vsync,
  output logic          kick
);
  localparam int FW = 32 - CW;
  localparam int NCFG = 5;
  localparam logic [31:0] M_LO  = (32'h1 << CW) - 32'h1;
  localparam logic [31:0] M_GEO = M_LO | (M_LO << 16);
  localparam logic [31:0] M_EN  = M_GEO | 32'h8000_0000;
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_HGEO  = AW'(1);
  localparam logic [AW-1:0] A_KICK  = AW'(5);
  localparam logic [AW-1:0] A_RUN   = AW'(6);
  localparam logic [AW-1:0] A_TOKEN = AW'(7);
  localparam logic [AW-1:0] A_STAMP = AW'(8);

  logic [31:0]   sh_q [NCFG];
  logic          shad_q, run_q, pend_q;
  logic [CW-1:0] x_q, y_q;
  logic [FW-1:0] frame_q;

  logic [CW-1:0] w_ht, w_ha, w_hsw, w_hsb;
  logic [CW-1:0] w_vt, w_va, w_vsw, w_vsb;
  logic [CW-1:0] w_kc, w_kr;
  logic          w_hen, w_ven, w_ken;

  logic eol, eof, cfg_wr;
  logic [AW-1:0] cfg_idx;

  assign eol     = run_q && (x_q >= w_ht);
  assign eof     = eol && (y_q >= w_vt);
  assign cfg_wr  = reg_we && (reg_addr >= A_HGEO) && (reg_addr <= A_KICK);
  assign cfg_idx = reg_addr - A_HGEO;

  function automatic logic [31:0] cfg_mask(input logic [AW-1:0] idx);
    return (idx == AW'(0) || idx == AW'(2)) ? M_GEO : M_EN;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCFG; i++) sh_q[i] <= '0;
      shad_q <= 1'b0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (eof && pend_q) pend_q <= 1'b0;
      if (reg_we) begin
        if (reg_addr == A_CTRL) shad_q <= reg_wdata[0];
        if (reg_addr == A_RUN) run_q <= reg_wdata[0];
        if (reg_addr == A_TOKEN && reg_wdata[0]) pend_q <= 1'b1;
      end
      for (int i = 0; i < NCFG; i++)
        if (cfg_wr && cfg_idx == AW'(i)) sh_q[i] <= reg_wdata & cfg_mask(AW'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {w_ht, w_ha, w_hsw, w_hsb} <= '0;
      {w_vt, w_va, w_vsw, w_vsb} <= '0;
      {w_kc, w_kr} <= '0;
      {w_hen, w_ven, w_ken} <= '0;
    end else begin
      if (eof && pend_q) begin
        w_ht  <= sh_q[0][16 +: CW];
        w_ha  <= sh_q[0][0 +: CW];
        w_hsb <= sh_q[1][16 +: CW];
        w_hsw <= sh_q[1][0 +: CW];
        w_hen <= sh_q[1][31];
        w_vt  <= sh_q[2][16 +: CW];
        w_va  <= sh_q[2][0 +: CW];
        w_vsb <= sh_q[3][16 +: CW];
        w_vsw <= sh_q[3][0 +: CW];
        w_ven <= sh_q[3][31];
        w_kr  <= sh_q[4][16 +: CW];
        w_kc  <= sh_q[4][0 +: CW];
        w_ken <= sh_q[4][31];
      end
      if (cfg_wr && !shad_q) begin
        case (cfg_idx)
          AW'(0): begin
            w_ht <= reg_wdata[16 +: CW];
            w_ha <= reg_wdata[0 +: CW];
          end
          AW'(1): begin
            w_hsb <= reg_wdata[16 +: CW];
            w_hsw <= reg_wdata[0 +: CW];
            w_hen <= reg_wdata[31];
          end
          AW'(2): begin
            w_vt <= reg_wdata[16 +: CW];
            w_va <= reg_wdata[0 +: CW];
          end
          AW'(3): begin
            w_vsb <= reg_wdata[16 +: CW];
            w_vsw <= reg_wdata[0 +: CW];
            w_ven <= reg_wdata[31];
          end
          default: begin
            w_kr  <= reg_wdata[16 +: CW];
            w_kc  <= reg_wdata[0 +: CW];
            w_ken <= reg_wdata[31];
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q     <= '0;
      y_q     <= '0;
      frame_q <= '0;
    end else if (!run_q) begin
      x_q <= '0;
      y_q <= '0;
    end else if (eol) begin
      x_q <= '0;
      if (eof) begin
        y_q     <= '0;
        frame_q <= frame_q + FW'(1);
      end else begin
        y_q <= y_q + CW'(1);
      end
    end else begin
      x_q <= x_q + CW'(1);
    end
  end

  logic [CW:0]   hs_beg, vs_beg;
  logic [CW+1:0] hs_end, vs_end;
  assign hs_beg = {1'b0, w_ht} - {1'b0, w_hsb};
  assign vs_beg = {1'b0, w_vt} - {1'b0, w_vsb};
  assign hs_end = {1'b0, hs_beg} + {2'b0, w_hsw} + (CW+2)'(1);
  assign vs_end = {1'b0, vs_beg} + {2'b0, w_vsw} + (CW+2)'(1);

  assign pix_x  = x_q;
  assign line_y = y_q;
  assign de     = run_q && (x_q < w_ha) && (y_q < w_va);
  assign hsync  = run_q && w_hen && !hs_beg[CW] &&
                  ({1'b0, x_q} >= hs_beg) && ({2'b0, x_q} < hs_end);
  assign vsync  = run_q && w_ven && !vs_beg[CW] &&
                  ({1'b0, y_q} >= vs_beg) && ({2'b0, y_q} < vs_end);
  assign kick   = run_q && w_ken && (x_q == w_kc) && (y_q == w_kr);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) reg_rdata = {31'b0, shad_q};
    else if (reg_addr == A_RUN) reg_rdata = {31'b0, run_q};
    else if (reg_addr == A_STAMP) reg_rdata = {frame_q, y_q};
    else if (reg_addr >= A_HGEO && reg_addr <= A_KICK) begin
      for (int i = 0; i < NCFG; i++)
        if (cfg_idx == AW'(i)) reg_rdata = sh_q[i];
    end
  end

  a_r2_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && x_q >= w_ht) |=> (x_q == '0));
  a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (x_q == '0 && y_q == '0));
  a_r6_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (frame_q == $past(frame_q) || frame_q == $past(frame_q) + FW'(1)));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !(de || hsync || vsync || kick));
  a_r7_token_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && pend_q && !(reg_we && reg_addr == A_TOKEN)) |=> !pend_q);
  a_r5_kick_gated: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> (x_q == w_kc && y_q == w_kr && w_ken));
endmodule

// File: tb/vtg_raster_test.sv
`timescale 1ns/100ps
module vtg_raster_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [13:0] pix_x, line_y;
  logic de, hsync, vsync, kick;

  vtg_raster uut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_x(pix_x), .line_y(line_y),
    .de(de), .hsync(hsync), .vsync(vsync), .kick(kick));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int m_x = 0, m_y = 0, m_frame = 0;
  bit m_run = 0, m_shad = 0, m_pend = 0;
  bit [31:0] m_sh [5];
  bit [31:0] m_wk [5];

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int fld(input bit [31:0] w, input int lo);
    return int'(w[lo +: 14]);
  endfunction

  function automatic bit sync_at(input int c, input bit [31:0] geo, input bit [31:0] syn);
    int b = fld(geo, 16) - fld(syn, 16);
    return syn[31] && b >= 0 && c >= b && c <= b + fld(syn, 0);
  endfunction

  task automatic step(input bit we, input int a, input bit [31:0] d);
    if (!m_run) begin
      m_x = 0; m_y = 0;
    end else if (m_x >= fld(m_wk[0], 16)) begin
      m_x = 0;
      if (m_y >= fld(m_wk[2], 16)) begin
        m_y = 0; m_frame++;
        if (m_pend) begin
          m_wk = m_sh; m_pend = 0;
        end
      end else m_y++;
    end else m_x++;
    if (we) begin
      if (a == 0) m_shad = d[0];
      if (a == 6) m_run = d[0];
      if (a == 7 && d[0]) m_pend = 1;
      if (a >= 1 && a <= 5) begin
        bit [31:0] v = d & ((a == 1 || a == 3) ? 32'h3FFF_3FFF : 32'hBFFF_3FFF);
        m_sh[a-1] = v;
        if (!m_shad) m_wk[a-1] = v;
      end
    end
  endtask

  task automatic tick();
    bit on = m_run;
    chk("R2 pix_x", pix_x, m_x);
    chk("R2 line_y", line_y, m_y);
    chk("R3 de", de, on && m_x < fld(m_wk[0], 0) && m_y < fld(m_wk[2], 0));
    chk("R4 hsync", hsync, on && sync_at(m_x, m_wk[0], m_wk[1]));
    chk("R4 vsync", vsync, on && sync_at(m_y, m_wk[2], m_wk[3]));
    chk("R5 kick", kick, on && m_wk[4][31] && m_x == fld(m_wk[4], 0) && m_y == fld(m_wk[4], 16));
    @(negedge clk);
    step(reg_we, int'(reg_addr), reg_wdata);
  endtask

  task automatic wr(input int a, input bit [31:0] d);
    reg_we = 1; reg_addr = 6'(a); reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic rd(input int a, output bit [31:0] d);
    reg_addr = 6'(a); #1; d = reg_rdata;
  endtask

  task automatic run_for(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  function automatic int frame_len();
    return (fld(m_wk[0], 16) + 1) * (fld(m_wk[2], 16) + 1);
  endfunction

  task automatic rand_cfg();
    int ht = 6 + $urandom % 15, ha = 1 + $urandom % (ht - 2);
    int hb = $urandom % (ht - ha + 1), hw = $urandom % (hb + 1);
    int vt = 3 + $urandom % 6, va = 1 + $urandom % (vt - 1);
    int vb = $urandom % (vt - va + 1), vw = $urandom % (vb + 1);
    bit he = ($urandom % 4) != 0, ve = ($urandom % 4) != 0, ke = ($urandom % 4) != 0;
    wr(1, (ht << 16) | ha);
    wr(2, {he, 1'b0, 14'(hb), 2'b0, 14'(hw)});
    wr(3, (vt << 16) | va);
    wr(4, {ve, 1'b0, 14'(vb), 2'b0, 14'(vw)});
    wr(5, {ke, 1'b0, 14'(va), 2'b0, 14'(ha + 1)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit [31:0] r;
    int seed;
    seed = int'($urandom(32'd2024));
    for (int i = 0; i < 5; i++) begin m_sh[i] = 0; m_wk[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 16; a++) begin rd(a, r); chk("R1 reg reset", r, 0); end
    chk("R1 outputs", {de, hsync, vsync, kick, pix_x, line_y}, 0);

    // R9 readback masking, read-only and write-only behaviour
    wr(1, 32'hFFFF_FFFF);
    rd(1, r); chk("R9 size mask", r, 32'h3FFF_3FFF);
    wr(2, 32'hFFFF_FFFF);
    rd(2, r); chk("R9 sync mask", r, 32'hBFFF_3FFF);
    wr(8, 32'h1234_5678);
    rd(8, r); chk("R9 stamp write ignored", r, 0);
    wr(7, 32'h0);
    rd(7, r); chk("R9 token reads zero", r, 0);
    rd(13, r); chk("R9 unmapped zero", r, 0);

    // R2..R6, R8 random geometries, immediate update
    for (int k = 0; k < 8; k++) begin
      rand_cfg();
      wr(6, 1);
      run_for(2 * frame_len() + int'($urandom % 50));
      rd(8, r); chk("R6 timestamp", r, {18'(m_frame), 14'(m_y)});
      wr(6, 0);
      run_for(2);
      rd(8, r); chk("R8 frame kept after stop", r, {18'(m_frame), 14'd0});
      chk("R8 stopped outputs", {de, hsync, vsync, kick, pix_x, line_y}, 0);
    end

    // R7 deferred update: held until token, applied at frame wrap
    rand_cfg();
    wr(0, 1);
    wr(6, 1);
    run_for(frame_len() / 2);
    wr(1, (32'd12 << 16) | 32'd3);
    rd(1, r); chk("R7 programmed copy visible", r, (32'd12 << 16) | 32'd3);
    run_for(2 * frame_len());
    chk("R7 held without token", int'(m_pend), 0);
    wr(7, 1);
    run_for(3 * frame_len() + 40);
    rd(0, r); chk("R7 control readback", r, 1);
    // directed: token on a stopped raster waits for the first wrap
    wr(6, 0);
    wr(2, 32'h8000_0000);
    wr(7, 1);
    run_for(5);
    wr(6, 1);
    run_for(2 * frame_len() + 30);
    rd(8, r); chk("R6 timestamp after deferred load", r, {18'(m_frame), 14'(m_y)});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule